// File: doc/BRIEF.md
# Packed Uniform Vector Loader

This block turns a stream of 32-bit configuration writes into whole four-component uniform vectors for a shader unit's constant store. A setup write chooses where the next vector goes and how the following data words are packed. Data words are then collected one at a time. When a full vector has arrived, the block unpacks it into four 24-bit floating-point components and presents it on a one-cycle write strobe toward the store. It then moves the target index on by one, so a long run of vectors can be loaded after a single setup write.

Two input encodings are supported. In single-precision mode each of four words carries one IEEE-754 single value, which is narrowed to the 24-bit format. In packed mode, three words carry four ready-made 24-bit components back to back. The block holds one independent loader per shader unit. A shared-mode input makes every write aimed at unit 0 also land in each other unit, so both stores receive the same vectors.

Writes arrive as a valid/ready stream. `wr_ready` is held high, so a beat moves on every cycle in which `wr_valid` is high. The store-side strobe has no back-pressure: the store must take each `cmt_valid` pulse in the cycle it appears.

Top module: `uniform_vec_loader`

## Requirements
- R1: After reset `cmt_valid` and `idx_err` are low and `wr_ready` is high. Every unit's index is 0, its word count is 0 and its mode is packed, so three data words with no prior setup commit to index 0.
- R2: A beat is taken only in a cycle where `wr_valid` and `wr_ready` are both high. Cycles with `wr_valid` low change no state, whatever the other inputs carry.
- R3: In single-precision mode (setup bit 31 = 1) a vector completes on the 4th data word. Data word i becomes component 3-i. `cmt_vec` is laid out as x in [23:0], y in [47:24], z in [71:48] and w in [95:72], so the first word fills w and the last fills x.
- R4: In packed mode (setup bit 31 = 0) a vector completes on the 3rd data word. Components are taken as follows: w = word0[31:8]; z = {word0[7:0], word1[31:16]}; y = {word1[15:0], word2[31:24]}; x = word2[23:0]. Together this makes `cmt_vec` equal to {word0, word1, word2}.
- R5: A single-precision word is narrowed to 24 bits in the order sign, 7-bit exponent with bias 63, 16-bit mantissa. The exponent is rebiased from 127 to 63 and the mantissa is truncated to its upper 16 bits. An input exponent of 64 or less, zero included, gives a signed zero. An input exponent of 191 or more, infinities and NaNs included, gives the sign with exponent 127 and mantissa all ones.
- R6: The cycle after the completing data word is taken, `cmt_valid` pulses for one cycle with `cmt_index` equal to the index in use. The unit's index then increases by one, and the word count returns to 0.
- R7: If the index is 96 or more when a vector completes, nothing is written. `idx_err` pulses for one cycle in place of `cmt_valid`, the index stays unchanged and the word count returns to 0.
- R8: A setup write loads the index from bits [6:0] and the mode from bit 31. It also discards any partially collected words.
- R9: While `shared_mode` is high, each setup and data write aimed at unit 0 (`wr_unit` = 0) is applied to unit 1 as well, so both units commit identical vectors in the same cycle.
- R10: A write aimed at unit 1 affects only unit 1, in either mode. While `shared_mode` is low, writes aimed at unit 0 leave unit 1 untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| shared_mode | input | 1 | Mirror unit-0 writes into the other unit |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Beat accepted (held high) |
| wr_unit | input | 1 | Target unit of the beat |
| wr_setup | input | 1 | 1: setup word, 0: data word |
| wr_data | input | 32 | Setup or data word |
| cmt_valid | output | 2 | Per-unit store write strobe |
| cmt_index | output | 14 | Per-unit store index, 7 bits per unit |
| cmt_vec | output | 192 | Per-unit vector, 96 bits per unit, x in the low bits |
| idx_err | output | 2 | Per-unit pulse: vector dropped, index out of range |

## Verification
A lost or extra word in a unit's count shifts the point at which a vector completes. That shows up as a commit arriving one beat early or late, with every component rotated, at the very next vector boundary. A wrong index register shows on `cmt_index` at the next commit, or as an early or missing `idx_err` near entry 95. A mirror fault shows as a unit-1 strobe missing, or an extra one appearing, in the same cycle as the unit-0 commit. The bench keeps an expected-event queue per unit, so any such mismatch is caught at the first strobe after it.

// File: rtl/uvl_pkg.sv
package uvl_pkg;
  localparam int WORD_W       = 32;
  localparam int COMP_W       = 24;
  localparam int NCOMP        = 4;
  localparam int VEC_W        = NCOMP * COMP_W;
  localparam int PACKED_WORDS = VEC_W / WORD_W;
  localparam int MODE_BIT     = 31;

  typedef enum logic {
    PACK_F24 = 1'b0,
    PACK_F32 = 1'b1
  } pack_mode_e;
endpackage

// File: rtl/uvl_f24_conv.sv
module uvl_f24_conv
  import uvl_pkg::*;
(
  input  logic [WORD_W-1:0] f_in,
  output logic [COMP_W-1:0] f_out
);
  localparam int IN_EXP_W    = 8;
  localparam int IN_MAN_W    = 23;
  localparam int OUT_EXP_W   = 7;
  localparam int OUT_MAN_W   = COMP_W - 1 - OUT_EXP_W;
  localparam int IN_BIAS     = (1 << (IN_EXP_W - 1)) - 1;
  localparam int OUT_BIAS    = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int BIAS_DIFF   = IN_BIAS - OUT_BIAS;
  localparam int OUT_EXP_MAX = (1 << OUT_EXP_W) - 1;

  logic                 sgn;
  logic [IN_EXP_W-1:0]  e_in;
  logic [IN_EXP_W:0]    e_ext;
  logic [OUT_MAN_W-1:0] m_top;
  logic [OUT_EXP_W-1:0] e_out;

  assign sgn   = f_in[WORD_W-1];
  assign e_in  = f_in[WORD_W-2 -: IN_EXP_W];
  assign e_ext = {1'b0, e_in};
  assign m_top = f_in[IN_MAN_W-1 -: OUT_MAN_W];
  assign e_out = OUT_EXP_W'(e_ext - (IN_EXP_W+1)'(BIAS_DIFF));

  always_comb begin
    if (e_ext <= (IN_EXP_W+1)'(BIAS_DIFF)) begin
      // underflow and zero: signed zero
      f_out = {sgn, {(COMP_W-1){1'b0}}};
    end else if (e_ext >= (IN_EXP_W+1)'(BIAS_DIFF + OUT_EXP_MAX)) begin
      // overflow, inf, NaN: saturate to largest magnitude
      f_out = {sgn, OUT_EXP_W'(OUT_EXP_MAX), {OUT_MAN_W{1'b1}}};
    end else begin
      f_out = {sgn, e_out, m_top};
    end
  end
endmodule

// File: rtl/uvl_vec_assemble.sv
module uvl_vec_assemble
  import uvl_pkg::*;
(
  input  pack_mode_e        mode,
  input  logic [WORD_W-1:0] words [NCOMP],
  output logic [VEC_W-1:0]  vec
);
  logic [VEC_W-1:0] f32_vec;
  logic [VEC_W-1:0] pk_vec;

  // single-precision: word i narrowed into component slot NCOMP-1-i
  generate
    for (genvar i = 0; i < NCOMP; i++) begin : g_cv
      uvl_f24_conv u_cv (
        .f_in (words[i]),
        .f_out(f32_vec[(NCOMP-1-i)*COMP_W +: COMP_W])
      );
    end
  endgenerate

  // packed: words laid end to end, first word in the top bits
  generate
    for (genvar j = 0; j < PACKED_WORDS; j++) begin : g_pk
      assign pk_vec[VEC_W-1-j*WORD_W -: WORD_W] = words[j];
    end
  endgenerate

  assign vec = (mode == PACK_F32) ? f32_vec : pk_vec;
endmodule

// File: rtl/uvl_unit.sv
module uvl_unit
  import uvl_pkg::*;
#(
  parameter int NUM_ENTRIES = 96,
  parameter int IDX_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_setup,
  input  logic [WORD_W-1:0] wr_data,
  output logic              cmt_valid,
  output logic [IDX_W-1:0]  cmt_index,
  output logic [VEC_W-1:0]  cmt_vec,
  output logic              idx_err
);
  localparam int CNT_W     = $clog2(NCOMP);
  localparam int BUF_DEPTH = NCOMP - 1;

  logic [IDX_W-1:0]  idx_q;
  pack_mode_e        mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] buf_q [BUF_DEPTH];
  logic [WORD_W-1:0] words [NCOMP];
  logic [CNT_W-1:0]  last_cnt;
  logic              data_wr;
  logic              complete;
  logic              in_range;
  logic [VEC_W-1:0]  asm_vec;

  assign data_wr  = wr_en && !wr_setup;
  assign last_cnt = (mode_q == PACK_F32) ? CNT_W'(NCOMP - 1) : CNT_W'(PACKED_WORDS - 1);
  assign complete = data_wr && (cnt_q == last_cnt);
  assign in_range = {1'b0, idx_q} < (IDX_W+1)'(NUM_ENTRIES);

  // the completing word is used live; earlier words come from the buffer
  generate
    for (genvar k = 0; k < NCOMP; k++) begin : g_word
      if (k < BUF_DEPTH) begin : g_buf
        assign words[k] = (data_wr && cnt_q == CNT_W'(k)) ? wr_data : buf_q[k];
      end else begin : g_live
        assign words[k] = wr_data;
      end
    end
  endgenerate

  uvl_vec_assemble u_asm (
    .mode (mode_q),
    .words(words),
    .vec  (asm_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      mode_q    <= PACK_F24;
      cnt_q     <= '0;
      cmt_valid <= 1'b0;
      cmt_index <= '0;
      cmt_vec   <= '0;
      idx_err   <= 1'b0;
      for (int k = 0; k < BUF_DEPTH; k++) buf_q[k] <= '0;
    end else begin
      cmt_valid <= 1'b0;
      idx_err   <= 1'b0;
      if (wr_en && wr_setup) begin
        idx_q  <= wr_data[IDX_W-1:0];
        mode_q <= pack_mode_e'(wr_data[MODE_BIT]);
        cnt_q  <= '0;
      end else if (complete) begin
        cnt_q <= '0;
        if (in_range) begin
          cmt_valid <= 1'b1;
          cmt_index <= idx_q;
          cmt_vec   <= asm_vec;
          idx_q     <= idx_q + IDX_W'(1);
        end else begin
          idx_err <= 1'b1;
        end
      end else if (data_wr) begin
        for (int k = 0; k < BUF_DEPTH; k++) begin
          if (cnt_q == CNT_W'(k)) buf_q[k] <= wr_data;
        end
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_CMT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> ({1'b0, cmt_index} < (IDX_W+1)'(NUM_ENTRIES)));  // R7
  AST_IDX_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> (idx_q == cmt_index + IDX_W'(1)));  // R6
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |-> !cmt_valid);  // R7
  AST_ERR_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |-> $stable(idx_q));  // R7
  AST_PACKED_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PACK_F24) |-> (cnt_q < CNT_W'(PACKED_WORDS)));  // R4
  AST_SETUP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_setup) |=> (cnt_q == '0));  // R8
endmodule

// File: rtl/uniform_vec_loader.sv
module uniform_vec_loader
  import uvl_pkg::*;
#(
  parameter int NUM_UNITS   = 2,
  parameter int NUM_ENTRIES = 96,
  parameter int IDX_W       = 7,
  localparam int UNIT_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shared_mode,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [UNIT_W-1:0]          wr_unit,
  input  logic                       wr_setup,
  input  logic [WORD_W-1:0]          wr_data,
  output logic [NUM_UNITS-1:0]       cmt_valid,
  output logic [NUM_UNITS*IDX_W-1:0] cmt_index,
  output logic [NUM_UNITS*VEC_W-1:0] cmt_vec,
  output logic [NUM_UNITS-1:0]       idx_err
);
  logic                 accept;
  logic [NUM_UNITS-1:0] hit;

  assign wr_ready = 1'b1;
  assign accept   = wr_valid && wr_ready;

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      if (u == 0) begin : g_primary
        assign hit[u] = accept && (wr_unit == UNIT_W'(0));
      end else begin : g_secondary
        assign hit[u] = accept && ((wr_unit == UNIT_W'(u)) ||
                                   (shared_mode && wr_unit == UNIT_W'(0)));
      end

      uvl_unit #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .IDX_W      (IDX_W)
      ) u_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hit[u]),
        .wr_setup (wr_setup),
        .wr_data  (wr_data),
        .cmt_valid(cmt_valid[u]),
        .cmt_index(cmt_index[u*IDX_W +: IDX_W]),
        .cmt_vec  (cmt_vec[u*VEC_W +: VEC_W]),
        .idx_err  (idx_err[u])
      );
    end
  endgenerate

  AST_MIRROR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_mode && hit[0]) |-> hit[NUM_UNITS-1]);  // R9
endmodule

// File: tb/test_uniform_vec_loader.sv
module test_uniform_vec_loader;
  import uvl_pkg::*;

  localparam int CLK_PERIOD  = 10;
  localparam int NUM_UNITS   = 2;
  localparam int NUM_ENTRIES = 96;
  localparam int IDX_W       = 7;
  localparam int ITEM_W      = 1 + IDX_W + VEC_W;

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b0;
  logic                       shared_mode = 1'b0;
  logic                       wr_valid = 1'b0;
  logic                       wr_ready;
  logic [0:0]                 wr_unit = '0;
  logic                       wr_setup = 1'b0;
  logic [WORD_W-1:0]          wr_data = '0;
  logic [NUM_UNITS-1:0]       cmt_valid;
  logic [NUM_UNITS*IDX_W-1:0] cmt_index;
  logic [NUM_UNITS*VEC_W-1:0] cmt_vec;
  logic [NUM_UNITS-1:0]       idx_err;

  uniform_vec_loader #(
    .NUM_UNITS(NUM_UNITS), .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
  ) i_uniform_vec_loader (
    .clk(clk), .rst_n(rst_n), .shared_mode(shared_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_unit(wr_unit),
    .wr_setup(wr_setup), .wr_data(wr_data),
    .cmt_valid(cmt_valid), .cmt_index(cmt_index), .cmt_vec(cmt_vec),
    .idx_err(idx_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // scoreboard queues, one per unit
  logic [ITEM_W-1:0] exp_q0[$];
  logic [ITEM_W-1:0] exp_q1[$];
  string             tag_q0[$];
  string             tag_q1[$];

  // reference model state
  logic [IDX_W-1:0]  m_idx [NUM_UNITS];
  bit                m_f32 [NUM_UNITS];
  int                m_cnt [NUM_UNITS];
  logic [WORD_W-1:0] m_buf [NUM_UNITS][NCOMP];

  task automatic check(input bit ok, input string tag, input logic [ITEM_W-1:0] got,
                       input logic [ITEM_W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // narrowing per R5: rebias 127->63, keep top 16 mantissa bits
  function automatic logic [COMP_W-1:0] ref_f24(input logic [31:0] f);
    int e;
    e = int'(f[30:23]);
    if (e <= 64) return {f[31], 23'd0};
    if (e >= 191) return {f[31], 7'h7F, 16'hFFFF};
    return {f[31], 7'(e - 64), f[22:7]};
  endfunction

  task automatic push(input int u, input logic [ITEM_W-1:0] item, input string tag);
    if (u == 0) begin exp_q0.push_back(item); tag_q0.push_back(tag); end
    else begin exp_q1.push_back(item); tag_q1.push_back(tag); end
  endtask

  task automatic model_apply(input int u, input bit setup, input logic [31:0] d,
                             input string tag);
    logic [VEC_W-1:0] v;
    if (setup) begin
      m_idx[u] = d[IDX_W-1:0];
      m_f32[u] = d[31];
      m_cnt[u] = 0;
    end else begin
      m_buf[u][m_cnt[u]] = d;
      if (m_cnt[u] == (m_f32[u] ? 3 : 2)) begin
        m_cnt[u] = 0;
        if (m_f32[u])
          v = {ref_f24(m_buf[u][0]), ref_f24(m_buf[u][1]),
               ref_f24(m_buf[u][2]), ref_f24(m_buf[u][3])};
        else
          v = {m_buf[u][0], m_buf[u][1], m_buf[u][2]};
        if (int'(m_idx[u]) < NUM_ENTRIES) begin
          push(u, {1'b0, m_idx[u], v}, tag);
          m_idx[u] = m_idx[u] + 1'b1;
        end else begin
          push(u, {1'b1, {(IDX_W+VEC_W){1'b0}}}, tag);
        end
      end else begin
        m_cnt[u]++;
      end
    end
  endtask

  task automatic wr(input int u, input bit setup, input logic [31:0] d, input string tag);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_unit  = 1'(u);
    wr_setup = setup;
    wr_data  = d;
    check(wr_ready == 1'b1, {tag, " R2 ready"}, ITEM_W'(wr_ready), ITEM_W'(1));
    model_apply(u, setup, d, tag);
    if (shared_mode && u == 0) model_apply(1, setup, d, tag);
  endtask

  // idle cycles with junk on the data lines (R2)
  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b0;
      wr_setup = i[0];
      wr_data  = $urandom;
      wr_unit  = 1'(i);
    end
  endtask

  task automatic setup_w(input int u, input int idx, input bit f32, input string tag);
    wr(u, 1'b1, {f32, 24'd0, 7'(idx)}, tag);
  endtask

  // monitor: pop and compare at each strobe
  always @(negedge clk) begin
    if (rst_n) begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (cmt_valid[u] || idx_err[u]) begin
          logic [ITEM_W-1:0] got;
          logic [ITEM_W-1:0] exp;
          string             tg;
          if (idx_err[u])
            got = {1'b1, {(IDX_W+VEC_W){1'b0}}};
          else
            got = {1'b0, cmt_index[u*IDX_W +: IDX_W], cmt_vec[u*VEC_W +: VEC_W]};
          if (cmt_valid[u] && idx_err[u]) check(1'b0, "R7 both strobes", got, '0);
          if ((u == 0 && exp_q0.size() == 0) || (u == 1 && exp_q1.size() == 0)) begin
            check(1'b0, $sformatf("R10 unexpected strobe unit%0d", u), got, '0);
          end else begin
            if (u == 0) begin exp = exp_q0.pop_front(); tg = tag_q0.pop_front(); end
            else begin exp = exp_q1.pop_front(); tg = tag_q1.pop_front(); end
            check(got == exp, $sformatf("%s unit%0d", tg, u), got, exp);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      m_idx[u] = '0; m_f32[u] = 1'b0; m_cnt[u] = 0;
      for (int k = 0; k < NCOMP; k++) m_buf[u][k] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cmt_valid == '0 && idx_err == '0 && wr_ready == 1'b1, "R1 reset outputs",
          ITEM_W'({cmt_valid, idx_err, wr_ready}), ITEM_W'(1));
    rst_n = 1'b1;

    // R1: default packed mode, index 0
    wr(0, 0, 32'hDEADBEEF, "R1 default");
    wr(0, 0, 32'h01234567, "R1 default");
    wr(0, 0, 32'h89ABCDEF, "R1 default");

    // R3 single-precision order
    setup_w(0, 5, 1, "R3");
    wr(0, 0, 32'h3F800000, "R3");
    wr(0, 0, 32'hC0000000, "R3");
    wr(0, 0, 32'h3F000000, "R3");
    wr(0, 0, 32'h40490FDB, "R3");

    // R4 packed slicing
    setup_w(0, 10, 0, "R4");
    wr(0, 0, 32'h11223344, "R4");
    wr(0, 0, 32'h55667788, "R4");
    wr(0, 0, 32'h99AABBCC, "R4");

    // R6 auto-increment, with idle gaps (R2)
    setup_w(0, 20, 1, "R6");
    for (int v = 0; v < 3; v++) begin
      for (int w = 0; w < 4; w++) begin
        wr(0, 0, 32'h3F800000 + 32'(v * 16 + w), "R6 R2");
        gap(w);
      end
    end

    // R5 special values: overflow, underflow, negative zero, NaN
    setup_w(0, 30, 1, "R5");
    wr(0, 0, 32'h7149F2CA, "R5");
    wr(0, 0, 32'h00800000, "R5");
    wr(0, 0, 32'h80000000, "R5");
    wr(0, 0, 32'hFFC00000, "R5");
    setup_w(0, 31, 1, "R5 edges");
    wr(0, 0, 32'h20000000, "R5 edges");
    wr(0, 0, 32'h20800000, "R5 edges");
    wr(0, 0, 32'h5F7FFFFF, "R5 edges");
    wr(0, 0, 32'hDF800000, "R5 edges");

    // R7 out-of-range at the top of the store
    setup_w(0, 95, 0, "R7");
    for (int v = 0; v < 3; v++) begin
      wr(0, 0, 32'hA0000000 + 32'(v), "R7");
      wr(0, 0, 32'hB0000000 + 32'(v), "R7");
      wr(0, 0, 32'hC0000000 + 32'(v), "R7");
    end
    setup_w(0, 127, 1, "R7 idx127");
    for (int w = 0; w < 4; w++) wr(0, 0, 32'h3F800000, "R7 idx127");

    // R8 setup drops partial words
    setup_w(0, 40, 1, "R8");
    wr(0, 0, 32'h11111111, "R8");
    wr(0, 0, 32'h22222222, "R8");
    setup_w(0, 41, 0, "R8");
    wr(0, 0, 32'h33333333, "R8");
    wr(0, 0, 32'h44444444, "R8");
    wr(0, 0, 32'h55555555, "R8");
    setup_w(0, 42, 0, "R8 mode switch");
    wr(0, 0, 32'h66666666, "R8 mode switch");
    setup_w(0, 43, 1, "R8 mode switch");
    for (int w = 0; w < 4; w++) wr(0, 0, 32'h40000000 + 32'(w << 20), "R8 mode switch");

    // R10 independent units, interleaved, not shared
    setup_w(1, 7, 1, "R10");
    setup_w(0, 50, 0, "R10");
    for (int w = 0; w < 4; w++) begin
      wr(1, 0, 32'h3E000000 + 32'(w << 16), "R10");
      if (w < 3) wr(0, 0, 32'hCAFE0000 + 32'(w), "R10");
    end

    // R9 shared mode mirroring
    @(negedge clk); wr_valid = 1'b0; shared_mode = 1'b1;
    setup_w(0, 60, 1, "R9");
    for (int w = 0; w < 4; w++) wr(0, 0, 32'h3F000000 + 32'(w << 12), "R9");
    wr(0, 0, 32'h0A0B0C0D, "R9 partial");
    // R10 in shared mode: unit-1 writes leave unit 0 alone
    setup_w(1, 70, 0, "R10 shared");
    for (int w = 0; w < 3; w++) wr(1, 0, 32'h77000000 + 32'(w), "R10 shared");
    setup_w(0, 61, 0, "R9");
    for (int w = 0; w < 3; w++) wr(0, 0, 32'h12340000 + 32'(w), "R9");

    // mixed random traffic
    for (int n = 0; n < 40; n++) begin
      int u;
      u = int'($urandom_range(0, 1));
      @(negedge clk); wr_valid = 1'b0; shared_mode = 1'($urandom_range(0, 1));
      setup_w(u, int'($urandom_range(0, 97)), 1'($urandom_range(0, 1)), "R3 R4 mix");
      for (int w = 0; w < 5; w++) begin
        wr(u, 0, $urandom, "R3 R4 mix");
        if ($urandom_range(0, 3) == 0) gap(1);
      end
    end

    gap(4);
    check(exp_q0.size() == 0 && exp_q1.size() == 0, "R6 all expected commits seen",
          ITEM_W'(exp_q0.size() + exp_q1.size()), '0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule